// File: doc/BRIEF.md
# Integer ALU with Selectively Updated Condition Flags

This block is a parameterised-width integer arithmetic and logic unit controlled by a 4-bit operation code. It produces a result word combinationally from two operands, together with a result-write strobe for the destination register. It also keeps five condition flags in a clocked status register: carry, zero, negative, overflow and parity. Each operation writes only the flags that mean something for it, and leaves the rest as they were.

The stored carry flag is fed back as the carry-in. This lets add-with-carry, subtract-with-borrow and rotate-through-carry chain across several words in multi-word arithmetic and shifts. Compare and test operations set the flags but keep the write strobe low, so a sequencer can use them for branch decisions without disturbing any register.

Shift and rotate each take a single opcode and move the operand by one bit. Operand B selects the variant: B[0]=0 shifts left and B[0]=1 shifts right. For a shift, B[1]=1 makes a right shift arithmetic. For a rotate, B[1]=1 passes the rotation through the carry flag.

Top module: `alu_cc_core`

## Requirements
- R1: The opcode encodings are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 NEG (0-A), 5 INC (A+1), 6 DEC (A-1), 7 CMP, 8 AND, 9 OR, 10 XOR, 11 NOT (~A), 12 TST, 13 PASS (A), 14 SHF and 15 ROT. The result y equals the named function of a, b and the stored carry, modulo 2^W.
- R2: After ADD and ADC, carry holds the carry out of bit W-1. After SUB, SBB, CMP and NEG, carry holds a borrow: it is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R3: ADD, ADC, SUB, SBB, CMP, NEG, INC and DEC set overflow when the signed two's-complement result falls outside the W-bit range, and clear it otherwise.
- R4: Every operation with op_valid high writes the remaining flags from y. Zero is 1 only when every bit of y is 0. Negative copies y[W-1]. Parity is 1 when y holds an odd number of 1 bits.
- R5: AND, OR, XOR, NOT, TST and PASS leave the stored carry and overflow flags unchanged.
- R6: CMP computes a-b and TST computes a&b, and both update flags as their base operation does. res_we stays 0 for them. For every other opcode res_we equals op_valid.
- R7: For SHF, B[0]=0 shifts left and inserts 0. B[0]=1 shifts right, inserting a[W-1] when B[1]=1 and 0 when B[1]=0. Carry takes the bit shifted out, and overflow is unchanged.
- R8: For ROT, B[0] selects left (0) or right (1). With B[1]=0 the end bits wrap into each other. With B[1]=1 the stored carry enters the vacated end, forming a W+1-bit ring. Carry takes the bit leaving the word, and overflow is unchanged.
- R9: The stored carry flag is the carry-in of ADC, the borrow-in of SBB and the ring bit of ROT through carry.
- R10: The flags change only on a rising clock edge with op_valid high. An asserted rst_n clears all five flags to 0.
- R11: INC and DEC leave the stored carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation present this cycle; enables the flag update |
| opcode | input | 4 | Operation select |
| a | input | W | First operand |
| b | input | W | Second operand; B[1:0] select the shift/rotate variant |
| y | output | W | Combinational result |
| res_we | output | 1 | Result-write strobe |
| flag_c | output | 1 | Stored carry / borrow flag |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_p | output | 1 | Stored parity flag (1 = odd) |

## Verification
The result y and res_we are combinational, so they are due in the same cycle the operands and opcode are applied. The flags are due one rising edge later. The bench drives each operation on a falling edge and queues its expected result, strobe and post-update flags. The monitor pops each queued item at the next rising edge, where it compares y and res_we while the inputs are still stable, and it compares the flags 2 ns after that edge, once the register has loaded. The bench keeps its own flag model, so each chained ADC, SBB or rotate-through-carry expectation uses the carry left by the operation queued before it.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int NFLAG = 5;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FP = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_NEG  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_CMP  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_TST  = 4'd12,
    OP_PASS = 4'd13,
    OP_SHF  = 4'd14,
    OP_ROT  = 4'd15
  } op_e;

  localparam logic [NFLAG-1:0] UPD_ALL   = 5'b11111;
  localparam logic [NFLAG-1:0] UPD_NOC   = 5'b11110;
  localparam logic [NFLAG-1:0] UPD_LOGIC = 5'b10110;
  localparam logic [NFLAG-1:0] UPD_SHIFT = 5'b10111;

endpackage

// File: rtl/alu_cc_exec.sv
module alu_cc_exec
  import alu_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]       opcode,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  output logic [W-1:0]     y,
  output logic [NFLAG-1:0] fl_new,
  output logic [NFLAG-1:0] fl_upd,
  output logic             writes
);

  localparam int WX = W + 1;

  logic [WX-1:0] ext;
  logic          c_out;
  logic          v_out;
  logic          fill;
  logic          sa, sb, sy;

  assign sa = a[W-1];
  assign sb = b[W-1];
  assign sy = y[W-1];

  always_comb begin
    ext    = '0;
    y      = a;
    c_out  = cin;
    v_out  = 1'b0;
    fill   = 1'b0;
    writes = 1'b1;
    fl_upd = UPD_LOGIC;
    case (op_e'(opcode))
      OP_ADD, OP_ADC: begin
        ext    = {1'b0, a} + {1'b0, b} +
                 {{W{1'b0}}, (op_e'(opcode) == OP_ADC) ? cin : 1'b0};
        y      = ext[W-1:0];
        c_out  = ext[W];
        v_out  = (sa == sb) && (ext[W-1] != sa);
        fl_upd = UPD_ALL;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        ext    = {1'b0, a} - {1'b0, b} -
                 {{W{1'b0}}, (op_e'(opcode) == OP_SBB) ? cin : 1'b0};
        y      = ext[W-1:0];
        c_out  = ext[W];
        v_out  = (sa != sb) && (ext[W-1] != sa);
        fl_upd = UPD_ALL;
        writes = (op_e'(opcode) != OP_CMP);
      end
      OP_NEG: begin
        ext    = {WX{1'b0}} - {1'b0, a};
        y      = ext[W-1:0];
        c_out  = ext[W];
        v_out  = sa && ext[W-1];
        fl_upd = UPD_ALL;
      end
      OP_INC: begin
        y      = a + {{(W-1){1'b0}}, 1'b1};
        v_out  = !sa && y[W-1];
        fl_upd = UPD_NOC;
      end
      OP_DEC: begin
        y      = a - {{(W-1){1'b0}}, 1'b1};
        v_out  = sa && !y[W-1];
        fl_upd = UPD_NOC;
      end
      OP_AND:  y = a & b;
      OP_TST: begin
        y      = a & b;
        writes = 1'b0;
      end
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_PASS: y = a;
      OP_SHF: begin
        fl_upd = UPD_SHIFT;
        if (b[0]) begin
          fill  = b[1] & a[W-1];
          y     = {fill, a[W-1:1]};
          c_out = a[0];
        end else begin
          y     = {a[W-2:0], 1'b0};
          c_out = a[W-1];
        end
      end
      OP_ROT: begin
        fl_upd = UPD_SHIFT;
        if (b[0]) begin
          fill  = b[1] ? cin : a[0];
          y     = {fill, a[W-1:1]};
          c_out = a[0];
        end else begin
          fill  = b[1] ? cin : a[W-1];
          y     = {a[W-2:0], fill};
          c_out = a[W-1];
        end
      end
      default: y = a;
    endcase
  end

  always_comb begin
    fl_new     = '0;
    fl_new[FC] = c_out;
    fl_new[FZ] = (y == '0);
    fl_new[FN] = sy;
    fl_new[FV] = v_out;
    fl_new[FP] = ^y;
  end

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NFLAG-1:0] fl_new,
  input  logic [NFLAG-1:0] fl_upd,
  output logic [NFLAG-1:0] fl_q
);

  logic [NFLAG-1:0] fl_d;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_comb begin
      fl_d[i] = fl_q[i];
      if (en && fl_upd[i]) fl_d[i] = fl_new[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  p_hold_without_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fl_q));

endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         res_we,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_p
);

  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic [NFLAG-1:0] fl_new;
  logic [NFLAG-1:0] fl_upd;
  logic [NFLAG-1:0] fl_q;
  logic             writes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  alu_cc_exec #(.W(W)) u_exec (
    .opcode (opcode),
    .a      (a),
    .b      (b),
    .cin    (fl_q[FC]),
    .y      (y),
    .fl_new (fl_new),
    .fl_upd (fl_upd),
    .writes (writes)
  );

  alu_cc_flagreg u_flags (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (op_valid),
    .fl_new (fl_new),
    .fl_upd (fl_upd),
    .fl_q   (fl_q)
  );

  assign res_we = op_valid & writes;
  assign flag_c = fl_q[FC];
  assign flag_z = fl_q[FZ];
  assign flag_n = fl_q[FN];
  assign flag_v = fl_q[FV];
  assign flag_p = fl_q[FP];

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    op_valid |=> (flag_z == ($past(y) == '0)));

  p_parity_flag_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    op_valid |=> (flag_p == ^$past(y)));

  p_logic_keeps_cv_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && (opcode inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST, OP_PASS}))
      |=> ($stable(flag_c) && $stable(flag_v)));

  p_no_write_cmp_tst_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && (opcode == OP_CMP || opcode == OP_TST)) |-> !res_we);

  p_write_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    res_we |-> op_valid);

  p_incdec_keeps_c_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && (opcode == OP_INC || opcode == OP_DEC)) |=> $stable(flag_c));

endmodule

// File: tb/tb_alu_cc_core.sv
`timescale 1ns/1ps
module tb_alu_cc_core;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid;
  logic [3:0]   opcode;
  logic [W-1:0] a, b;
  logic [W-1:0] y;
  logic         res_we;
  logic         flag_c, flag_z, flag_n, flag_v, flag_p;

  always #5 clk = ~clk;

  alu_cc_core #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .a(a), .b(b), .y(y), .res_we(res_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_p(flag_p)
  );

  typedef struct {
    string    tag;
    logic [7:0] ey;
    logic       ewe;
    logic [4:0] ef;
  } item_t;

  item_t      sb_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [4:0] mflags;
  bit         finished = 0;

  function automatic logic [4:0] dut_flags();
    return {flag_p, flag_v, flag_n, flag_z, flag_c};
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic [7:0] ia, input logic [7:0] ib,
                                input logic [4:0] fin, output logic [7:0] oy,
                                output logic owe, output logic [4:0] fo);
    int ua, ub, sa, sb, r, sr, ci;
    bit c, v, uc, uv;
    ua = ia; ub = ib; sa = $signed(ia); sb = $signed(ib);
    ci = fin[0]; c = fin[0]; v = fin[3]; uc = 0; uv = 0; owe = 1; r = 0; sr = 0;
    case (op)
      4'd0, 4'd1: begin
        r = ua + ub + ((op == 4'd1) ? ci : 0); sr = sa + sb + ((op == 4'd1) ? ci : 0);
        c = (r > 255); uc = 1; uv = 1;
      end
      4'd2, 4'd3, 4'd7: begin
        r = ua - ub - ((op == 4'd3) ? ci : 0); sr = sa - sb - ((op == 4'd3) ? ci : 0);
        c = (ua < ub + ((op == 4'd3) ? ci : 0)); uc = 1; uv = 1;
        if (op == 4'd7) owe = 0;
      end
      4'd4: begin r = -ua; sr = -sa; c = (ua != 0); uc = 1; uv = 1; end
      4'd5: begin r = ua + 1; sr = sa + 1; uv = 1; end
      4'd6: begin r = ua - 1; sr = sa - 1; uv = 1; end
      4'd8: r = ua & ub;
      4'd12: begin r = ua & ub; owe = 0; end
      4'd9: r = ua | ub;
      4'd10: r = ua ^ ub;
      4'd11: r = 255 - ua;
      4'd13: r = ua;
      4'd14: begin
        uc = 1;
        if (ib[0]) begin r = ua / 2 + ((ib[1] && ia[7]) ? 128 : 0); c = ia[0]; end
        else begin r = (ua * 2) % 256; c = ia[7]; end
      end
      default: begin
        uc = 1;
        if (ib[0]) begin r = ua / 2 + ((ib[1] ? ci : int'(ia[0])) * 128); c = ia[0]; end
        else begin r = (ua * 2) % 256 + (ib[1] ? ci : int'(ia[7])); c = ia[7]; end
      end
    endcase
    v = uv ? (sr > 127 || sr < -128) : v;
    oy = r[7:0];
    fo = fin;
    if (uc) fo[0] = c;
    fo[1] = (oy == 8'h00);
    fo[2] = oy[7];
    if (uv) fo[3] = v;
    fo[4] = ^oy;
  endfunction

  task automatic drive(string tag, logic vld, logic [3:0] op, logic [7:0] ia, logic [7:0] ib);
    item_t it;
    logic [7:0] ey; logic ewe; logic [4:0] ef;
    @(negedge clk);
    op_valid = vld; opcode = op; a = ia; b = ib;
    model(op, ia, ib, mflags, ey, ewe, ef);
    it.tag = tag; it.ey = ey;
    it.ewe = vld ? ewe : 1'b0;
    it.ef  = vld ? ef : mflags;
    mflags = it.ef;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, "y", int'(y), int'(it.ey));
        check(it.tag, "res_we", int'(res_we), int'(it.ewe));
        #2;
        check(it.tag, "flags{p,v,n,z,c}", int'(dut_flags()), int'(it.ef));
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; op_valid = 1'b0; opcode = 4'd0; a = '0; b = '0;
    mflags = 5'b00000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R10", "reset flags", int'(dut_flags()), 0);
    check("R6", "idle res_we", int'(res_we), 0);

    drive("R1",  1, 4'd0,  8'h12, 8'h34);
    drive("R2",  1, 4'd0,  8'hFF, 8'h01);
    drive("R9",  1, 4'd1,  8'h10, 8'h20);
    drive("R3",  1, 4'd0,  8'h7F, 8'h01);
    drive("R2",  1, 4'd2,  8'h05, 8'h07);
    drive("R9",  1, 4'd3,  8'h10, 8'h01);
    drive("R3",  1, 4'd2,  8'h80, 8'h01);
    drive("R1",  1, 4'd4,  8'h01, 8'h00);
    drive("R3",  1, 4'd4,  8'h80, 8'h00);
    drive("R11", 1, 4'd5,  8'hFF, 8'h00);
    drive("R11", 1, 4'd6,  8'h80, 8'h00);
    drive("R6",  1, 4'd7,  8'h33, 8'h33);
    drive("R2",  1, 4'd7,  8'h10, 8'h20);
    drive("R5",  1, 4'd8,  8'hF0, 8'h3C);
    drive("R5",  1, 4'd9,  8'h00, 8'h00);
    drive("R5",  1, 4'd10, 8'hAA, 8'h55);
    drive("R5",  1, 4'd11, 8'h0F, 8'h00);
    drive("R6",  1, 4'd12, 8'hF0, 8'h0F);
    drive("R4",  1, 4'd13, 8'h07, 8'h00);
    drive("R4",  1, 4'd13, 8'h81, 8'h00);
    drive("R7",  1, 4'd14, 8'h81, 8'h00);
    drive("R7",  1, 4'd14, 8'h81, 8'h01);
    drive("R7",  1, 4'd14, 8'h81, 8'h03);
    drive("R7",  1, 4'd14, 8'h40, 8'h03);
    drive("R8",  1, 4'd15, 8'h81, 8'h00);
    drive("R8",  1, 4'd15, 8'h01, 8'h01);
    drive("R2",  1, 4'd2,  8'h00, 8'h01);
    drive("R9",  1, 4'd15, 8'h02, 8'h03);
    drive("R9",  1, 4'd15, 8'h80, 8'h02);
    drive("R9",  1, 4'd15, 8'h00, 8'h02);
    drive("R10", 0, 4'd2,  8'h00, 8'h01);
    drive("R10", 0, 4'd0,  8'hFF, 8'hFF);
    drive("R1",  1, 4'd10, 8'h3C, 8'h0F);
    drive("R1",  1, 4'd9,  8'h30, 8'h03);

    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule